// File: doc/BRIEF.md
# Branch and Jump Target Resolver

This block settles control flow for one decoded control-transfer instruction per cycle. The decode stage presents a kind code together with the two register operands, the current program counter, a 16-bit signed word offset, a 26-bit absolute jump index and a register-held jump address. One clock later the resolver reports whether control moves, the address to fetch next, and whether the return address must be written to register 31, along with that address.

Instructions are 4 bytes wide, so both the relative offset and the absolute index count words and are shifted left by two before use. Register-equality branches, signed comparisons of the first operand against zero, their link-writing forms, absolute jumps, absolute calls and register-indirect jumps all share one comparison and adder path. A register-indirect address with nonzero low bits is passed through unchanged and is reported on a separate misalignment flag.

Top module: `branch_resolver`

## Requirements
- R1: A request with `req_vld` high is resolved in the next cycle, with `res_vld` high there; while `res_vld` is low (including after reset), `res_taken`, `res_link_we` and `res_misalign` are 0.
- R2: Kind 0 is taken when `op_a` equals `op_b`; kind 1 is taken when they differ.
- R3: Kinds 2, 3, 4 and 5 treat `op_a` as two's complement and are taken when it is at most zero, above zero, below zero and at least zero respectively.
- R4: A taken relative branch (kinds 0 to 7) sets `res_next_pc` to `cur_pc + 4 + (sign-extended rel_off << 2)`; any request that is not taken sets it to `cur_pc + 4`, with 32-bit wraparound.
- R5: Kind 6 is taken when `op_a` is below zero and kind 7 when it is at least zero; both raise `res_link_we` with `res_link_val = cur_pc + 4` whether taken or not.
- R6: Kind 8 is always taken with `res_next_pc` equal to bits 31:28 of `cur_pc + 4`, then `jmp_idx`, then two zero bits; kind 9 does the same and also links `cur_pc + 4`.
- R7: Kind 10 is always taken with `res_next_pc = reg_tgt` unchanged; `res_misalign` is 1 exactly when `reg_tgt[1:0]` is nonzero, and 0 for every other kind.
- R8: Kinds 11 to 15 are not control transfers: not taken, fall through to `cur_pc + 4`, no link.
- R9: `res_link_we` is raised only for kinds 6, 7 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_kind | input | 4 | Transfer kind code |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| cur_pc | input | 32 | Address of the control instruction |
| rel_off | input | 16 | Signed word offset for relative branches |
| jmp_idx | input | 26 | Word index for absolute jumps |
| reg_tgt | input | 32 | Register-held jump address |
| res_vld | output | 1 | Result present this cycle |
| res_taken | output | 1 | Control leaves the sequential path |
| res_next_pc | output | 32 | Next fetch address |
| res_link_we | output | 1 | Write return address to register 31 |
| res_link_val | output | 32 | Return address |
| res_misalign | output | 1 | Register jump address not word aligned |

## Verification
The signed compares are driven with zero, one, minus one and the most negative value, which separates at-most from below and at-least from above and catches an unsigned compare. The equality kinds get equal and unequal pairs that differ only in the top bit. Offsets of both signs and a program counter near the top of memory tell sign extension and wraparound apart, while absolute jumps from a program counter with nonzero upper bits show those bits are kept. Link kinds are run both taken and not taken, and register jumps with each nonzero low-bit pattern.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [3:0]       req_kind,
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [OFF_W-1:0] rel_off,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic [XLEN-1:0]  reg_tgt,
  output logic             res_vld,
  output logic             res_taken,
  output logic [XLEN-1:0]  res_next_pc,
  output logic             res_link_we,
  output logic [XLEN-1:0]  res_link_val,
  output logic             res_misalign
);
  localparam int HI_W = XLEN - IDX_W - 2;
  localparam int EXT_W = XLEN - OFF_W - 2;

  localparam logic [3:0] K_EQ   = 4'd0;
  localparam logic [3:0] K_NE   = 4'd1;
  localparam logic [3:0] K_LEZ  = 4'd2;
  localparam logic [3:0] K_GTZ  = 4'd3;
  localparam logic [3:0] K_LTZ  = 4'd4;
  localparam logic [3:0] K_GEZ  = 4'd5;
  localparam logic [3:0] K_LTZL = 4'd6;
  localparam logic [3:0] K_GEZL = 4'd7;
  localparam logic [3:0] K_J    = 4'd8;
  localparam logic [3:0] K_JL   = 4'd9;
  localparam logic [3:0] K_JR   = 4'd10;

  logic [XLEN-1:0] seq_pc, rel_tgt, abs_tgt, tgt;
  logic neg, zero, eq, cond, is_rel, take, link, mis;

  assign seq_pc  = cur_pc + XLEN'(4);
  assign rel_tgt = seq_pc + {{EXT_W{rel_off[OFF_W-1]}}, rel_off, 2'b00};
  assign abs_tgt = {seq_pc[XLEN-1 -: HI_W], jmp_idx, 2'b00};
  assign neg     = op_a[XLEN-1];
  assign zero    = (op_a == '0);
  assign eq      = (op_a == op_b);
  assign is_rel  = (req_kind <= K_GEZL);

  always_comb begin
    cond = 1'b0;
    link = 1'b0;
    tgt  = rel_tgt;
    mis  = 1'b0;
    case (req_kind)
      K_EQ:   cond = eq;
      K_NE:   cond = !eq;
      K_LEZ:  cond = neg || zero;
      K_GTZ:  cond = !neg && !zero;
      K_LTZ:  cond = neg;
      K_GEZ:  cond = !neg;
      K_LTZL: begin cond = neg;  link = 1'b1; end
      K_GEZL: begin cond = !neg; link = 1'b1; end
      K_J:    begin cond = 1'b1; tgt = abs_tgt; end
      K_JL:   begin cond = 1'b1; tgt = abs_tgt; link = 1'b1; end
      K_JR:   begin cond = 1'b1; tgt = reg_tgt; mis = (reg_tgt[1:0] != 2'b00); end
      default: cond = 1'b0;
    endcase
    take = cond && (is_rel || req_kind <= K_JR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld      <= 1'b0;
      res_taken    <= 1'b0;
      res_next_pc  <= '0;
      res_link_we  <= 1'b0;
      res_link_val <= '0;
      res_misalign <= 1'b0;
    end else begin
      res_vld      <= req_vld;
      res_taken    <= req_vld && take;
      res_next_pc  <= take ? tgt : seq_pc;
      res_link_we  <= req_vld && link;
      res_link_val <= seq_pc;
      res_misalign <= req_vld && mis;
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic [3:0]       req_kind,
  input logic [XLEN-1:0]  op_a,
  input logic [XLEN-1:0]  op_b,
  input logic [XLEN-1:0]  cur_pc,
  input logic [XLEN-1:0]  reg_tgt,
  input logic             res_vld,
  input logic             res_taken,
  input logic [XLEN-1:0]  res_next_pc,
  input logic             res_link_we,
  input logic [XLEN-1:0]  res_link_val,
  input logic             res_misalign
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> (!res_taken && !res_link_we && !res_misalign));

  p_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 4'd0) |=> (res_taken == ($past(op_a) == $past(op_b))));

  p_fallthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (res_taken || res_next_pc == $past(cur_pc) + XLEN'(4)));

  p_link_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (!res_link_we || res_link_val == $past(cur_pc) + XLEN'(4)));

  p_regjump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind == 4'd10) |=>
      (res_taken && res_next_pc == $past(reg_tgt) && res_misalign == ($past(reg_tgt[1:0]) != 2'b00)));

  p_link_kinds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_kind != 4'd6 && req_kind != 4'd7 && req_kind != 4'd9) |=> !res_link_we);
endmodule

bind branch_resolver branch_resolver_chk #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
  .op_a(op_a), .op_b(op_b), .cur_pc(cur_pc), .reg_tgt(reg_tgt),
  .res_vld(res_vld), .res_taken(res_taken), .res_next_pc(res_next_pc),
  .res_link_we(res_link_we), .res_link_val(res_link_val), .res_misalign(res_misalign)
);

// File: tb/sim_branch_resolver.sv
`timescale 1ns/1ps
module sim_branch_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [3:0]  req_kind = '0;
  logic [31:0] op_a = '0, op_b = '0, cur_pc = '0, reg_tgt = '0;
  logic [15:0] rel_off = '0;
  logic [25:0] jmp_idx = '0;
  logic        res_vld, res_taken, res_link_we, res_misalign;
  logic [31:0] res_next_pc, res_link_val;

  always #2.5 clk = ~clk;

  branch_resolver u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
    .op_a(op_a), .op_b(op_b), .cur_pc(cur_pc), .rel_off(rel_off),
    .jmp_idx(jmp_idx), .reg_tgt(reg_tgt), .res_vld(res_vld),
    .res_taken(res_taken), .res_next_pc(res_next_pc), .res_link_we(res_link_we),
    .res_link_val(res_link_val), .res_misalign(res_misalign)
  );

  typedef struct {
    logic        taken;
    logic [31:0] npc;
    logic        lwe;
    logic [31:0] lval;
    logic        mis;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  function automatic exp_t model(input logic [3:0] k, input logic [31:0] a, b, pc,
                                 input logic [15:0] off, input logic [25:0] idx,
                                 input logic [31:0] rt, input string tag);
    exp_t e;
    logic signed [31:0] sa;
    logic [31:0] nxt, brt, jt;
    sa  = a;
    nxt = pc + 32'd4;
    brt = nxt + (32'($signed(off)) * 32'sd4);
    jt  = {nxt[31:28], idx, 2'b00};
    e.taken = 0; e.npc = nxt; e.lwe = 0; e.lval = nxt; e.mis = 0; e.tag = tag;
    case (k)
      4'd0: e.taken = (a == b);
      4'd1: e.taken = (a != b);
      4'd2: e.taken = (sa <= 0);
      4'd3: e.taken = (sa > 0);
      4'd4: e.taken = (sa < 0);
      4'd5: e.taken = (sa >= 0);
      4'd6: begin e.taken = (sa < 0);  e.lwe = 1; end
      4'd7: begin e.taken = (sa >= 0); e.lwe = 1; end
      4'd8: begin e.taken = 1; e.npc = jt; end
      4'd9: begin e.taken = 1; e.npc = jt; e.lwe = 1; end
      4'd10: begin e.taken = 1; e.npc = rt; e.mis = (rt[1:0] != 0); end
      default: ;
    endcase
    if (e.taken && k <= 4'd7) e.npc = brt;
    return e;
  endfunction

  task automatic drive(input logic [3:0] k, input logic [31:0] a, b, pc,
                       input logic [15:0] off, input logic [25:0] idx,
                       input logic [31:0] rt, input string tag);
    req_vld = 1; req_kind = k; op_a = a; op_b = b; cur_pc = pc;
    rel_off = off; jmp_idx = idx; reg_tgt = rt;
    sb.push_back(model(k, a, b, pc, off, idx, rt, tag));
    @(negedge clk);
    req_vld = 0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (res_vld || res_taken || res_link_we || res_misalign) begin
      fails++;
      $display("FAIL %s idle: vld=%b taken=%b lwe=%b mis=%b expected all 0",
               tag, res_vld, res_taken, res_link_we, res_misalign);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && res_vld) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected result: vld=1 expected 0");
        end else begin
          e = sb.pop_front();
          if (res_taken !== e.taken || res_next_pc !== e.npc || res_link_we !== e.lwe ||
              (e.lwe && res_link_val !== e.lval) || res_misalign !== e.mis) begin
            fails++;
            $display("FAIL %s: taken=%b npc=%h lwe=%b lval=%h mis=%b expected taken=%b npc=%h lwe=%b lval=%h mis=%b",
                     e.tag, res_taken, res_next_pc, res_link_we, res_link_val, res_misalign,
                     e.taken, e.npc, e.lwe, e.lval, e.mis);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 after reset");

    drive(4'd0, 32'h1234, 32'h1234, 32'h0000_1000, 16'h0010, 0, 0, "R2 equal taken");
    drive(4'd0, 32'h8000_1234, 32'h1234, 32'h0000_1000, 16'h0010, 0, 0, "R2 equal not taken");
    drive(4'd1, 32'h8000_0000, 32'h0, 32'h0000_2000, 16'hFFFF, 0, 0, "R2 R4 unequal negative offset");
    drive(4'd1, 32'h55, 32'h55, 32'h0000_2000, 16'hFFFF, 0, 0, "R2 unequal not taken");
    gap(2);
    check_idle("R1 gap");

    drive(4'd2, 32'h0, 0, 32'h100, 16'h0004, 0, 0, "R3 lez zero");
    drive(4'd2, 32'h1, 0, 32'h100, 16'h0004, 0, 0, "R3 lez one");
    drive(4'd2, 32'hFFFF_FFFF, 0, 32'h100, 16'h8000, 0, 0, "R3 R4 lez minus one max back");
    drive(4'd3, 32'h0, 0, 32'h100, 16'h0004, 0, 0, "R3 gtz zero");
    drive(4'd3, 32'h1, 0, 32'h100, 16'h7FFF, 0, 0, "R3 R4 gtz one max fwd");
    drive(4'd3, 32'h8000_0000, 0, 32'h100, 16'h0004, 0, 0, "R3 gtz most negative");
    drive(4'd4, 32'h8000_0000, 0, 32'h300, 16'h0002, 0, 0, "R3 ltz most negative");
    drive(4'd4, 32'h0, 0, 32'h300, 16'h0002, 0, 0, "R3 ltz zero");
    drive(4'd5, 32'h0, 0, 32'h300, 16'h0002, 0, 0, "R3 gez zero");
    drive(4'd5, 32'hFFFF_FFFF, 0, 32'h300, 16'h0002, 0, 0, "R3 gez minus one");
    drive(4'd5, 32'h7FFF_FFFF, 0, 32'hFFFF_FFFC, 16'h0001, 0, 0, "R4 wraparound");

    drive(4'd6, 32'hFFFF_FFF0, 0, 32'h4000, 16'h0008, 0, 0, "R5 ltz link taken");
    drive(4'd6, 32'h10, 0, 32'h4000, 16'h0008, 0, 0, "R5 ltz link not taken");
    drive(4'd7, 32'h0, 0, 32'h5000, 16'hFFF0, 0, 0, "R5 gez link taken");
    drive(4'd7, 32'h8000_0000, 0, 32'h5000, 16'hFFF0, 0, 0, "R5 gez link not taken");

    drive(4'd8, 0, 0, 32'hA000_0010, 0, 26'h3FF_FFFF, 0, "R6 jump upper bits");
    drive(4'd8, 0, 0, 32'hEFFF_FFFC, 0, 26'h000_0001, 0, "R6 jump seq carry");
    drive(4'd9, 0, 0, 32'h5000_0040, 0, 26'h123_4567, 0, "R6 R9 call");

    drive(4'd10, 0, 0, 32'h600, 0, 0, 32'h0040_0100, "R7 reg jump aligned");
    drive(4'd10, 0, 0, 32'h600, 0, 0, 32'h0040_0101, "R7 reg jump low1");
    drive(4'd10, 0, 0, 32'h600, 0, 0, 32'h0040_0102, "R7 reg jump low2");
    drive(4'd10, 0, 0, 32'h600, 0, 0, 32'h0040_0103, "R7 reg jump low3");
    drive(4'd1, 1, 2, 32'h600, 0, 0, 32'h0040_0103, "R7 no misalign other kind");

    drive(4'd11, 1, 1, 32'h700, 16'h0010, 26'h1, 32'h3, "R8 R9 kind 11");
    drive(4'd15, 0, 0, 32'h700, 16'h0010, 26'h1, 32'h3, "R8 R9 kind 15");
    gap(3);
    check_idle("R1 drained");
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R1 missing results: %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule